// File: doc/BRIEF.md
# Interrupt Claim-Complete Controller

This block collects a handful of level-sensitive interrupt lines and presents them to one or two targets. Software assigns each source a 3-bit priority and, per target, a set of enabled sources plus a priority threshold. A target sees its request line high whenever an enabled, pending source beats its threshold.

The target services interrupts through a claim/complete register. Reading it claims the best enabled pending source and returns its ID. Writing an ID to it completes that source. Each source has its own small gateway state machine, so any number of sources may be claimed and still open at once. They may be completed in any order, and a completion is never matched against the most recent claim.

The gateway per source has three states:
- `GW_IDLE`: the source is waiting.
- `GW_PEND`: a request is latched.
- `GW_INSVC`: the source has been claimed and is not yet completed.

Its transitions are:
- *arrive* (`GW_IDLE`→`GW_PEND`): the line is high.
- *claim* (`GW_PEND`→`GW_INSVC`): a target claims this source.
- *complete* (`GW_INSVC`→`GW_IDLE`): a valid completion names this source.

Every other case holds the current state.

Top module: `irq_claim_ctrl`

## Requirements
- R1: After reset, the following all read 0 and both `irq_o` bits are low:
  - every priority, enable and threshold register;
  - every claim.
- R2: The register map, on 8-bit word addresses, is:
  - Address N, for N from 1 to 7, holds source N's priority in data bits [2:0].
  - Address 0x10+t holds target t's enable mask, with source N at data bit N.
  - Address 0x20+2t holds target t's threshold in bits [2:0].
  - Address 0x21+2t is target t's claim/complete register.
  Written values read back as stored.
- R3: Any other address reads 0, and a write to it changes no register. Address 0, 0x08, 0x12 and 0x30 are examples. No access ever signals an error.
- R4: `irq_o[t]` is high exactly when some source that is pending and enabled for t has a priority strictly greater than t's threshold.
- R5: A claim read returns the pending source enabled for that target with the highest priority, with ties going to the lowest ID. The threshold is ignored, and the claim returns 0 when no such source exists.
- R6: A claim moves the returned source from pending to in service at the same clock edge. A source whose line rises in the cycle of a claim is not considered by that claim.
- R7: A source in service never becomes pending again while its line stays high. Several sources may be in service at once.
- R8: A completion may name any in-service source enabled for that target, regardless of the last claim. If that source's line is still high, it becomes pending one cycle after the completion.
- R9: A completion whose ID is 0, out of range, or not enabled for the writing target is silently ignored. The named source stays in service.
- R10: A source with priority 0 never raises `irq_o` and is never returned by a claim.
- R11: A pending request is latched. Dropping the line after it became pending does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 7 | Level interrupt lines; bit k is source k+1 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (claims on claim address) |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid combinationally while reg_rd is high |
| irq_o | output | 2 | Per-target interrupt request |

## Verification
Two functions can collide in one cycle: a claim read, and a new source line arriving at its gateway. The bench raises a fresh line in the very cycle it reads the claim register. It then checks that this claim returns the older pending source and that the next claim returns the newcomer. A second collision is a completion landing while the completed source's line is still high. A claim read straight after the completion must return 0, and the following claim must return that source. A behavioural model compares the request lines on every clock and every read value.

// File: rtl/icc_pkg.sv
package icc_pkg;
    typedef enum logic [1:0] {
        GW_IDLE  = 2'd0,
        GW_PEND  = 2'd1,
        GW_INSVC = 2'd2
    } gw_state_e;

    localparam int PRIO_W   = 3;
    localparam int EN_BASE  = 16;
    localparam int TGT_BASE = 32;
endpackage

// File: rtl/icc_gateway.sv
module icc_gateway
    import icc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pend_o,
    output logic insvc_o
);
    gw_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GW_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE:  if (level_i)    state_d = GW_PEND;
            GW_PEND:  if (claim_i)    state_d = GW_INSVC;
            GW_INSVC: if (complete_i) state_d = GW_IDLE;
            default:                  state_d = GW_IDLE;
        endcase
    end

    always_comb begin
        pend_o  = (state_q == GW_PEND);
        insvc_o = (state_q == GW_INSVC);
    end
endmodule

// File: rtl/icc_arbiter.sv
module icc_arbiter
    import icc_pkg::*;
#(
    parameter int NSRC = 7,
    parameter int IDW  = 3
) (
    input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [NSRC-1:0]             eligible_i,
    input  logic [PRIO_W-1:0]           thr_i,
    output logic [IDW-1:0]              id_o,
    output logic                        irq_o
);
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        best_p = '0;
        id_o   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (eligible_i[i] && (prio_i[i] > best_p)) begin
                best_p = prio_i[i];
                id_o   = IDW'(i + 1);
            end
        end
        irq_o = (best_p > thr_i);
    end
endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl
    import icc_pkg::*;
#(
    parameter int NSRC = 7,
    parameter int NTGT = 2,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic [NTGT-1:0] irq_o
);
    localparam int IDW = $clog2(NSRC + 1);

    logic [NSRC-1:0][PRIO_W-1:0] prio_q;
    logic [NTGT-1:0][NSRC-1:0]   en_q;
    logic [NTGT-1:0][PRIO_W-1:0] thr_q;
    logic [NTGT-1:0][IDW-1:0]    best_id;
    logic [NSRC-1:0]             pend_vec, insvc_vec, claim_vec, complete_vec;

    function automatic logic at(input logic [AW-1:0] a, input int off);
        return a == AW'(off);
    endfunction

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (reg_wr) begin
            for (int i = 0; i < NSRC; i++)
                if (at(reg_addr, i + 1)) prio_q[i] <= reg_wdata[PRIO_W-1:0];
            for (int t = 0; t < NTGT; t++) begin
                if (at(reg_addr, EN_BASE + t))      en_q[t]  <= reg_wdata[NSRC:1];
                if (at(reg_addr, TGT_BASE + 2 * t)) thr_q[t] <= reg_wdata[PRIO_W-1:0];
            end
        end
    end

    // Claim and completion strobes per source
    always_comb begin
        claim_vec    = '0;
        complete_vec = '0;
        for (int t = 0; t < NTGT; t++) begin
            for (int i = 0; i < NSRC; i++) begin
                if (reg_rd && at(reg_addr, TGT_BASE + 2 * t + 1) && best_id[t] == IDW'(i + 1))
                    claim_vec[i] = 1'b1;
                if (reg_wr && at(reg_addr, TGT_BASE + 2 * t + 1) &&
                    reg_wdata == DW'(i + 1) && en_q[t][i])
                    complete_vec[i] = 1'b1;
            end
        end
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            for (int i = 0; i < NSRC; i++)
                if (at(reg_addr, i + 1)) reg_rdata = DW'(prio_q[i]);
            for (int t = 0; t < NTGT; t++) begin
                if (at(reg_addr, EN_BASE + t))          reg_rdata = DW'({en_q[t], 1'b0});
                if (at(reg_addr, TGT_BASE + 2 * t))     reg_rdata = DW'(thr_q[t]);
                if (at(reg_addr, TGT_BASE + 2 * t + 1)) reg_rdata = DW'(best_id[t]);
            end
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_gw
        icc_gateway u_gw (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_i    (src_i[g]),
            .claim_i    (claim_vec[g]),
            .complete_i (complete_vec[g]),
            .pend_o     (pend_vec[g]),
            .insvc_o    (insvc_vec[g])
        );
    end

    for (genvar t = 0; t < NTGT; t++) begin : g_tgt
        icc_arbiter #(.NSRC(NSRC), .IDW(IDW)) u_arb (
            .prio_i     (prio_q),
            .eligible_i (pend_vec & en_q[t]),
            .thr_i      (thr_q[t]),
            .id_o       (best_id[t]),
            .irq_o      (irq_o[t])
        );
    end
endmodule

// File: rtl/irq_claim_ctrl_chk.sv
module irq_claim_ctrl_chk #(
    parameter int NSRC = 7,
    parameter int NTGT = 2,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_rd,
    input logic [AW-1:0]   reg_addr,
    input logic [DW-1:0]   reg_rdata,
    input logic [NTGT-1:0] irq_o,
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] insvc
);
    logic is_claim;
    always_comb begin
        is_claim = 1'b0;
        for (int t = 0; t < NTGT; t++)
            if (reg_addr == AW'(8'h21 + 2 * t)) is_claim = 1'b1;
    end

    // R3
    far_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr[AW-1:6] != '0) |-> reg_rdata == '0);

    // R5
    empty_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && is_claim && pend == '0) |-> reg_rdata == '0);

    // R4
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> (pend != '0));

    // R6
    state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & insvc) == '0);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        // R6
        claim_insvc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && is_claim && reg_rdata == DW'(i + 1)) |=> insvc[i]);
        // R7
        no_repend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            insvc[i] |=> !pend[i]);
    end
endmodule

bind irq_claim_ctrl irq_claim_ctrl_chk #(.NSRC(NSRC), .NTGT(NTGT), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o),
    .pend      (pend_vec),
    .insvc     (insvc_vec)
);

// File: tb/irq_claim_ctrl_tb_top.sv
module irq_claim_ctrl_tb_top;
    localparam int NS = 7;
    localparam int NT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:0] src_lines = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NT-1:0] irq_o;

    int n_tests = 0, n_fail = 0;
    int last_rd;

    // behavioural model: state 0 idle, 1 pending, 2 in service
    int m_prio[1:NS];
    int m_st[1:NS];
    int m_en[NT];
    int m_thr[NT];

    always #10 clk = ~clk;

    irq_claim_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_lines),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int m_best(input int t);
        int bp = 0, bid = 0;
        for (int id = 1; id <= NS; id++)
            if (m_st[id] == 1 && m_en[t][id] && m_prio[id] > bp) begin
                bp = m_prio[id]; bid = id;
            end
        return bid;
    endfunction

    function automatic bit m_irq(input int t);
        int b = m_best(t);
        return (b != 0) && (m_prio[b] > m_thr[t]);
    endfunction

    function automatic int m_read(input int a);
        if (a >= 1 && a <= NS) return m_prio[a];
        for (int t = 0; t < NT; t++) begin
            if (a == 'h10 + t)     return m_en[t];
            if (a == 'h20 + 2 * t) return m_thr[t];
            if (a == 'h21 + 2 * t) return m_best(t);
        end
        return 0;
    endfunction

    function automatic void m_reset();
        for (int id = 1; id <= NS; id++) begin m_prio[id] = 0; m_st[id] = 0; end
        for (int t = 0; t < NT; t++) begin m_en[t] = 0; m_thr[t] = 0; end
    endfunction

    function automatic void m_step(input bit w, input bit r, input int a, input int d, input logic [NS-1:0] ln);
        int cl = 0, cp = 0;
        for (int t = 0; t < NT; t++) begin
            if (r && a == 'h21 + 2 * t) cl = m_best(t);
            if (w && a == 'h21 + 2 * t && d >= 1 && d <= NS && m_en[t][d]) cp = d;
        end
        if (w) begin
            if (a >= 1 && a <= NS) m_prio[a] = d & 7;
            for (int t = 0; t < NT; t++) begin
                if (a == 'h10 + t)     m_en[t] = d & 'hFE;
                if (a == 'h20 + 2 * t) m_thr[t] = d & 7;
            end
        end
        for (int id = 1; id <= NS; id++) begin
            if (m_st[id] == 0 && ln[id-1]) m_st[id] = 1;
            else if (m_st[id] == 1 && cl == id) m_st[id] = 2;
            else if (m_st[id] == 2 && cp == id) m_st[id] = 0;
        end
    endfunction

    task automatic cyc(input bit w, input bit r, input int a, input int d, input string tag);
        @(negedge clk);
        reg_wr = w; reg_rd = r; reg_addr = 8'(a); reg_wdata = 32'(d);
        #1;
        for (int t = 0; t < NT; t++) chk("R4 irq", int'(irq_o[t]), int'(m_irq(t)));
        if (r) begin
            last_rd = int'(reg_rdata);
            chk(tag, last_rd, m_read(a));
        end
        @(posedge clk);
        m_step(w, r, a, d, src_lines);
        #1;
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        cyc(1'b1, 1'b0, a, d, "");
    endtask
    task automatic rd(input int a, input string tag);
        cyc(1'b0, 1'b1, a, 0, tag);
    endtask
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 0, 0, "");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd('h01, "R1 prio"); chk("R1 prio", last_rd, 0);
        rd('h10, "R1 en");   chk("R1 en", last_rd, 0);
        rd('h22, "R1 thr");
        rd('h21, "R1 claim"); chk("R1 claim", last_rd, 0);

        // R2 programming and readback
        wr('h01, 3); wr('h02, 5); wr('h03, 5); wr('h04, 0);
        wr('h05, 7); wr('h06, 1); wr('h07, 2);
        wr('h10, 'hFE); wr('h11, 'h60);
        wr('h20, 0); wr('h22, 4);
        rd('h05, "R2 prio"); chk("R2 prio", last_rd, 7);
        rd('h11, "R2 en");   chk("R2 en", last_rd, 'h60);
        rd('h22, "R2 thr");  chk("R2 thr", last_rd, 4);

        // R3 unmapped addresses
        wr('h00, 7); wr('h08, 7); wr('h12, 'hFF); wr('h30, 5);
        rd('h00, "R3 rd0");  chk("R3 rd0", last_rd, 0);
        rd('h08, "R3 rd8");  chk("R3 rd8", last_rd, 0);
        rd('h12, "R3 rd12"); chk("R3 rd12", last_rd, 0);
        rd('h30, "R3 rd30"); chk("R3 rd30", last_rd, 0);
        rd('h04, "R3 prio4 untouched"); chk("R3 prio4", last_rd, 0);

        // R10 priority 0 source
        src_lines[3] = 1'b1;
        idle(3);
        chk("R10 irq", int'(irq_o[0]), 0);
        rd('h21, "R10 claim"); chk("R10 claim", last_rd, 0);

        // R5 tie goes to lowest ID, R6 claim removes it, R7 no re-pend
        src_lines[1] = 1'b1; src_lines[2] = 1'b1;
        idle(1);
        rd('h21, "R5 tie"); chk("R5 tie", last_rd, 2);
        rd('h21, "R6 second"); chk("R6 second", last_rd, 3);
        rd('h21, "R7 none"); chk("R7 none", last_rd, 0);
        idle(3);
        rd('h21, "R7 still none"); chk("R7 still none", last_rd, 0);

        // R5 threshold ignored by claim
        wr('h20, 7);
        src_lines[4] = 1'b1; src_lines[0] = 1'b1;
        idle(1);
        chk("R4 thr blocks", int'(irq_o[0]), 0);
        chk("R4 t1 high", int'(irq_o[1]), 1);
        rd('h21, "R5 thr ignored"); chk("R5 thr ignored", last_rd, 5);
        rd('h21, "R5 next"); chk("R5 next", last_rd, 1);

        // R8 out-of-order completion, re-pend one cycle later
        wr('h21, 3);
        rd('h21, "R8 not yet"); chk("R8 not yet", last_rd, 0);
        rd('h21, "R8 repend"); chk("R8 repend", last_rd, 3);

        // R9 ignored completions
        wr('h20, 0);
        wr('h23, 2); wr('h21, 0); wr('h21, 9);
        idle(2);
        rd('h21, "R9 ignored"); chk("R9 ignored", last_rd, 0);
        wr('h21, 2);
        idle(1);
        rd('h21, "R9 valid"); chk("R9 valid", last_rd, 2);

        // R11 latched request
        src_lines[5] = 1'b1;
        idle(1);
        src_lines[5] = 1'b0;
        idle(2);
        chk("R11 irq", int'(irq_o[0]), 1);
        rd('h23, "R11 claim"); chk("R11 claim", last_rd, 6);

        // R6 claim in the same cycle as a new arrival
        wr('h21, 1);
        idle(1);
        src_lines[6] = 1'b1;
        rd('h21, "R6 same cycle"); chk("R6 same cycle", last_rd, 1);
        rd('h21, "R6 newcomer"); chk("R6 newcomer", last_rd, 7);
        idle(2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule